// File: doc/BRIEF.md
# Three-wire control-port receiver

This block is a write-only serial control slave for an audio converter. A host drives three lines into it: a serial clock, a serial data line and a mode line. The block brings all three lines into the system clock domain and gathers data bits on rising serial-clock edges, most significant bit first. It assembles them into bytes. While the mode line is low, each byte is an address byte. Its upper six bits name a device, and its lower two bits name a register class. While the mode line is high, each byte is a data byte. Its upper two bits pick a sub-register within the selected class, and its lower six bits are the value written into that sub-register.

There are two banks of four 6-bit sub-registers. The data bank holds volume, de-emphasis and mute settings. The status bank holds clock-rate and input-format settings. Both banks are presented as parallel outputs. An address selection stays in force for any number of data bytes until the next address byte arrives. Each write produces a one-cycle strobe together with the index of the register that was written.

Top module: `ctlrx_top`

## Requirements
- R1: After reset both banks read zero, no strobe is raised and the block is deselected, so a data byte sent before any address byte writes nothing.
- R2: An address byte (mode line low) whose bits 7..2 equal the device ID 000101 selects the block. Any other ID deselects it, and later data bytes write nothing.
- R3: Address bits 1..0 choose the class: 00 is the data bank and 10 is the status bank. With 01 or 11 no write occurs.
- R4: In a data byte (mode line high), bits 7..6 are the sub-register index and bits 5..0 are the value stored there.
- R5: A selection persists across consecutive data bytes until a new address byte arrives.
- R6: A register changes only after all 8 bits of a byte have arrived. A change on the mode line clears the bit count and discards any partial byte.
- R7: Each write raises wr_stb_o for exactly one cycle. wr_idx_o bit 2 is 1 for the status bank and 0 for the data bank, and bits 1..0 give the sub-register.
- R8: Bits are taken on rising edges of the serial clock, most significant bit first.
- R9: A write changes only the addressed sub-register. Every other sub-register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock from the host |
| ser_mode_i | input | 1 | Mode line: low for address bytes, high for data bytes |
| ser_dat_i | input | 1 | Serial data, MSB first |
| data_bank_o | output | 24 | Data-class sub-registers, sub k at bits 6k+5..6k |
| stat_bank_o | output | 24 | Status-class sub-registers, sub k at bits 6k+5..6k |
| wr_stb_o | output | 1 | One-cycle pulse per committed write |
| wr_idx_o | output | 3 | Index of the written register {class, sub} |

## Verification
The assertions assume that the serial clock is slow compared with the system clock. Consecutive committed bytes must therefore be many system cycles apart, so that a strobe and a byte-valid pulse can never fall in adjacent cycles. They also assume that the mode line never changes in the same cycle as a rising serial-clock edge. The stimulus holds each serial clock phase for four system cycles and changes the mode line only while the serial clock is low. It waits several cycles before and after each mode change. The stimulus sweeps all 256 address byte values, each paired with a data byte.

// File: rtl/ctlrx_pkg.sv
package ctlrx_pkg;
  typedef enum logic [1:0] {
    XFER_DATA  = 2'b00,
    XFER_RSV1  = 2'b01,
    XFER_STAT  = 2'b10,
    XFER_RSV3  = 2'b11
  } xfer_e;
endpackage

// File: rtl/ctlrx_sync.sv
module ctlrx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ctlrx_shift.sv
module ctlrx_shift #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              mode_i,
  input  logic              dat_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_mode_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic              sclk_q, mode_q;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              vld_q, vld_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              bmode_q, bmode_d;
  logic              rise, mode_chg;

  always_comb begin
    rise     = sclk_i & ~sclk_q;
    mode_chg = mode_i ^ mode_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    vld_d    = 1'b0;
    byte_d   = byte_q;
    bmode_d  = bmode_q;
    if (mode_chg) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (rise) begin
      sh_d = {sh_q[BYTE_W-2:0], dat_i};
      if (cnt_q == CNT_LAST) begin
        cnt_d   = '0;
        vld_d   = 1'b1;
        byte_d  = {sh_q[BYTE_W-2:0], dat_i};
        bmode_d = mode_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      mode_q  <= 1'b0;
      sh_q    <= '0;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
      byte_q  <= '0;
      bmode_q <= 1'b0;
    end else begin
      sclk_q  <= sclk_i;
      mode_q  <= mode_i;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      vld_q   <= vld_d;
      byte_q  <= byte_d;
      bmode_q <= bmode_d;
    end
  end

  assign byte_vld_o  = vld_q;
  assign byte_o      = byte_q;
  assign byte_mode_o = bmode_q;
endmodule

// File: rtl/ctlrx_decode.sv
module ctlrx_decode
  import ctlrx_pkg::*;
#(
  parameter int unsigned SUB_W  = 6,
  parameter int unsigned N_SUB  = 4,
  parameter int unsigned BYTE_W = 8,
  parameter logic [BYTE_W-3:0] DEV_ID = 6'b000101
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     byte_vld_i,
  input  logic [BYTE_W-1:0]        byte_i,
  input  logic                     byte_mode_i,
  output logic [N_SUB*SUB_W-1:0]   data_bank_o,
  output logic [N_SUB*SUB_W-1:0]   stat_bank_o,
  output logic                     wr_stb_o,
  output logic [$clog2(N_SUB):0]   wr_idx_o,
  output logic                     sel_o
);
  localparam int unsigned IDX_W = $clog2(N_SUB);

  logic              sel_q, sel_d;
  xfer_e             cls_q, cls_d;
  logic              stb_q, stb_d;
  logic [IDX_W:0]    idx_q, idx_d;
  logic              is_addr, is_data, dat_en, st_en;
  logic [IDX_W-1:0]  sub;
  logic [SUB_W-1:0]  val;

  always_comb begin
    is_addr = byte_vld_i & ~byte_mode_i;
    is_data = byte_vld_i & byte_mode_i & sel_q;
    sub     = byte_i[BYTE_W-1 -: IDX_W];
    val     = byte_i[SUB_W-1:0];
    dat_en  = is_data && (cls_q == XFER_DATA);
    st_en   = is_data && (cls_q == XFER_STAT);
    sel_d   = sel_q;
    cls_d   = cls_q;
    if (is_addr) begin
      sel_d = (byte_i[BYTE_W-1:2] == DEV_ID);
      cls_d = xfer_e'(byte_i[1:0]);
    end
    stb_d = dat_en | st_en;
    idx_d = (dat_en | st_en) ? {st_en, sub} : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      cls_q <= XFER_DATA;
      stb_q <= 1'b0;
      idx_q <= '0;
    end else begin
      sel_q <= sel_d;
      cls_q <= cls_d;
      stb_q <= stb_d;
      idx_q <= idx_d;
    end
  end

  for (genvar g = 0; g < N_SUB; g++) begin : g_bank
    logic [SUB_W-1:0] dat_q, st_q;
    logic             dat_we, st_we;
    assign dat_we = dat_en && (sub == IDX_W'(g));
    assign st_we  = st_en && (sub == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q <= '0;
        st_q  <= '0;
      end else begin
        if (dat_we) dat_q <= val;
        if (st_we)  st_q  <= val;
      end
    end
    assign data_bank_o[g*SUB_W +: SUB_W] = dat_q;
    assign stat_bank_o[g*SUB_W +: SUB_W] = st_q;
  end

  assign wr_stb_o = stb_q;
  assign wr_idx_o = idx_q;
  assign sel_o    = sel_q;
endmodule

// File: rtl/ctlrx_top.sv
module ctlrx_top #(
  parameter int unsigned SUB_W       = 6,
  parameter int unsigned N_SUB       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [5:0]  DEV_ID      = 6'b000101
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_clk_i,
  input  logic                   ser_mode_i,
  input  logic                   ser_dat_i,
  output logic [N_SUB*SUB_W-1:0] data_bank_o,
  output logic [N_SUB*SUB_W-1:0] stat_bank_o,
  output logic                   wr_stb_o,
  output logic [$clog2(N_SUB):0] wr_idx_o
);
  localparam int unsigned IDX_W  = $clog2(N_SUB);
  localparam int unsigned BYTE_W = IDX_W + SUB_W;

  logic [1:0]        rst_q;
  logic              rst_int_n;
  logic [2:0]        lines_s;
  logic              byte_vld, byte_mode, sel;
  logic [BYTE_W-1:0] byte_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  ctlrx_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({ser_clk_i, ser_mode_i, ser_dat_i}),
    .q_o   (lines_s)
  );

  ctlrx_shift #(.BYTE_W(BYTE_W)) i_shift (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sclk_i      (lines_s[2]),
    .mode_i      (lines_s[1]),
    .dat_i       (lines_s[0]),
    .byte_vld_o  (byte_vld),
    .byte_o      (byte_val),
    .byte_mode_o (byte_mode)
  );

  ctlrx_decode #(
    .SUB_W  (SUB_W),
    .N_SUB  (N_SUB),
    .BYTE_W (BYTE_W),
    .DEV_ID (DEV_ID[BYTE_W-3:0])
  ) i_decode (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .byte_vld_i  (byte_vld),
    .byte_i      (byte_val),
    .byte_mode_i (byte_mode),
    .data_bank_o (data_bank_o),
    .stat_bank_o (stat_bank_o),
    .wr_stb_o    (wr_stb_o),
    .wr_idx_o    (wr_idx_o),
    .sel_o       (sel)
  );
endmodule

// File: rtl/ctlrx_chk.sv
module ctlrx_chk #(
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned BANK_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_vld,
  input logic              byte_mode,
  input logic              sel,
  input logic              wr_stb,
  input logic [IDX_W:0]    wr_idx,
  input logic [BANK_W-1:0] data_bank,
  input logic [BANK_W-1:0] stat_bank
);
  // R7
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R6
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  // R2
  sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(sel) && $past(byte_vld) && $past(byte_mode)));

  // R3
  addr_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !byte_mode) |=> !wr_stb);

  // R9
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> ($stable(data_bank) && $stable(stat_bank)));

  // R7
  stat_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_idx[IDX_W]) |-> $stable(data_bank));

  // R7
  data_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wr_idx[IDX_W]) |-> $stable(stat_bank));
endmodule

bind ctlrx_top ctlrx_chk #(.IDX_W(IDX_W), .BANK_W(N_SUB*SUB_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .byte_vld  (byte_vld),
  .byte_mode (byte_mode),
  .sel       (sel),
  .wr_stb    (wr_stb_o),
  .wr_idx    (wr_idx_o),
  .data_bank (data_bank_o),
  .stat_bank (stat_bank_o)
);

// File: tb/test_ctlrx_top.sv
module test_ctlrx_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, sclk, smode, sdat;
  logic [23:0] data_bank, stat_bank;
  logic        wr_stb;
  logic [2:0]  wr_idx;

  ctlrx_top i_ctlrx_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_clk_i   (sclk),
    .ser_mode_i  (smode),
    .ser_dat_i   (sdat),
    .data_bank_o (data_bank),
    .stat_bank_o (stat_bank),
    .wr_stb_o    (wr_stb),
    .wr_idx_o    (wr_idx)
  );

  int         checks = 0;
  int         fails  = 0;
  int         stb_cnt = 0;
  logic [2:0] last_idx = '0;
  int         exp_stb = 0;
  logic [2:0] exp_idx = '0;
  logic [5:0] m_dat [4];
  logic [5:0] m_st  [4];
  bit         m_sel = 1'b0;
  logic [1:0] m_cls = 2'b00;

  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      stb_cnt++;
      last_idx = wr_idx;
    end
  end

  task automatic check_val(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pack(input logic [5:0] r [4]);
    return {r[3], r[2], r[1], r[0]};
  endfunction

  task automatic check_all(string req);
    check_val(req, {data_bank, stat_bank}, {pack(m_dat), pack(m_st)});
    check_val({req, " strobe count R7"}, 48'(stb_cnt), 48'(exp_stb));
    if (exp_stb > 0) check_val({req, " index R7"}, 48'(last_idx), 48'(exp_idx));
  endtask

  // Sends the top nbits of b (MSB first, R8); only a full byte updates the model.
  task automatic send_bits(bit md, logic [7:0] b, int nbits);
    if (smode != md) begin
      smode = md;
      repeat (6) @(negedge clk);
    end
    for (int i = 7; i > 7 - nbits; i--) begin
      sdat = b[i];
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (6) @(negedge clk);
    if (nbits == 8) begin
      if (!md) begin
        m_sel = (b[7:2] == 6'b000101);
        m_cls = b[1:0];
      end else if (m_sel && m_cls == 2'b00) begin
        m_dat[b[7:6]] = b[5:0];
        exp_stb++;
        exp_idx = {1'b0, b[7:6]};
      end else if (m_sel && m_cls == 2'b10) begin
        m_st[b[7:6]] = b[5:0];
        exp_stb++;
        exp_idx = {1'b1, b[7:6]};
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      m_dat[k] = '0;
      m_st[k]  = '0;
    end
    rst_n = 1'b0; sclk = 1'b0; smode = 1'b0; sdat = 1'b0;
    repeat (5) @(negedge clk);
    // R1: reset state
    check_val("R1 reset banks", {data_bank, stat_bank}, 48'd0);
    check_val("R1 reset strobe", 48'(wr_stb), 48'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1: deselected out of reset
    send_bits(1'b1, 8'h3F, 8);
    check_all("R1 data before address");

    // R2 R3 R4 R9: sweep every address byte, each followed by one data byte
    for (int a = 0; a < 256; a++) begin
      logic [7:0] ab, db;
      ab = 8'(a);
      db = {ab[1:0] ^ ab[3:2], 6'((a * 7 + 3) & 63)};
      send_bits(1'b0, ab, 8);
      send_bits(1'b1, db, 8);
      check_all("R2 R3 R4 R9 sweep");
    end

    // R5: multibyte into the data bank, then into the status bank
    send_bits(1'b0, 8'h14, 8);
    for (int s = 0; s < 4; s++) begin
      send_bits(1'b1, {2'(s), 6'(11 * s + 5)}, 8);
      check_all("R5 data multibyte");
    end
    send_bits(1'b0, 8'h16, 8);
    for (int s = 3; s >= 0; s--) begin
      send_bits(1'b1, {2'(s), 6'(60 - 9 * s)}, 8);
      check_all("R5 status multibyte");
    end

    // R3: reserved classes write nothing
    send_bits(1'b0, 8'h15, 8);
    send_bits(1'b1, 8'h2A, 8);
    check_all("R3 class 01");
    send_bits(1'b0, 8'h17, 8);
    send_bits(1'b1, 8'hC1, 8);
    check_all("R3 class 11");

    // R2: foreign ID deselects
    send_bits(1'b0, 8'h18, 8);
    send_bits(1'b1, 8'h55, 8);
    check_all("R2 foreign id");

    // R6: partial data byte dropped at mode change
    send_bits(1'b0, 8'h14, 8);
    send_bits(1'b1, 8'hFF, 5);
    send_bits(1'b0, 8'h14, 8);
    check_all("R6 partial data byte");
    send_bits(1'b1, 8'b10_000001, 8);
    check_all("R6 R8 realigned byte");
    check_val("R8 msb first sub2", 48'(data_bank[17:12]), 48'd1);

    // R6: partial address byte dropped at mode change
    send_bits(1'b0, 8'h18, 3);
    send_bits(1'b1, 8'h7E, 8);
    check_all("R6 partial address byte");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule